// File: doc/BRIEF.md
# Board Interrupt Priority Aggregator

This block gathers thirteen level-sensitive interrupt request lines from the peripherals on a board and reduces them to one 4-bit encoded interrupt level for the processor. Each request line is copied every clock into a 16-bit monitor word. Each source has its own bit in that word, and the bits are scattered rather than packed. Software writes a 16-bit enable mask. The block picks the most urgent source that is both active and enabled, where urgency is a fixed level number per source (0 is the most urgent). It drives the one's complement of that level, so a quiet board shows level 0 on the output.

A small 16-bit register window sits on a simple single-cycle read/write bus. It holds the enable mask, a general-purpose output port, a constant version word and a power-off control. Writing the power-off control with bit 0 set raises a one-cycle shutdown request for the board's power logic. The source input vector is indexed by level number: `src_req_i[k]` is the source whose level is k.

Top module: `irq_level_agg`

## Requirements
- R1: Source k (`src_req_i[k]`, k = 0..12) owns one monitor bit. In level order 0..12 these bits are 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. A high line sets its bit and a low line clears it, and the monitor word is sampled on every clock.
- R2: The selected level is the smallest k whose monitor bit is set and whose mask bit is also set. When no such k exists the level is 15, so the output never shows the values 1 or 2.
- R3: `irq_level_o` equals the selected level XOR 15. A block with nothing active and enabled drives 0.
- R4: `irq_level_o` is registered. It reflects the request lines and the mask write sampled at the previous rising edge, so a mask write takes effect one clock after its bus cycle.
- R5: The mask register at byte offset 0x00 stores and reads back all 16 bits. Mask bits 1, 2 and 3 have no source and never change the output.
- R6: The output port register at offset 0x36 stores any 16-bit write, reads it back and drives it on `port_o` one clock after the write.
- R7: The version register at offset 0x32 always reads 0x0010, and writes to it are ignored.
- R8: The power-off register at offset 0x30 reads 0x0000. A write with bit 0 set makes `shutdown_o` high for exactly the following clock. A write with bit 0 clear produces no pulse.
- R9: Reads of any other offset in the 0x40-byte window return 0x0000, and writes to other offsets change no register or output.
- R10: Reset (`rst_n` low) clears the mask, the monitor word, the output port, `shutdown_o` and `irq_level_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 13 | Level request lines, bit k is the source of level k |
| bus_sel_i | input | 1 | Bus cycle valid this clock |
| bus_wr_i | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_i | input | 6 | Byte offset inside the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the same cycle as the read |
| irq_level_o | output | 4 | Encoded interrupt level (selected level XOR 15) |
| port_o | output | 16 | General output port value |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
On every cycle the assertions check three things. The output is 0 whenever nothing is both active and enabled. The encoded values 1 and 2 never appear. The mask and port registers move only under a write to their own offset, and every shutdown pulse traces back to a power-off write with bit 0 set. Other behaviour cannot be stated as a single-cycle property: the priority order between several simultaneous sources, the scattered mask bit assignment, the inert mask bits 1 to 3 and the exact read values of the window. The bench scenarios show these, together with a behavioural model that it compares against the design on every clock.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int NUM_SRC   = 13;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 6;
    localparam int LEVEL_W   = 4;

    localparam logic [ADDR_W-1:0] OFS_MASK  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_POWER = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_VER   = 6'h32;
    localparam logic [ADDR_W-1:0] OFS_PORT  = 6'h36;

    localparam logic [DATA_W-1:0] VERSION_WORD = 16'h0010;

    // Monitor/mask bit owned by the source whose priority level is lvl.
    function automatic int unsigned src_bit(input int unsigned lvl);
        case (lvl)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            12:      return 15;
            default: return 1;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] port;
        logic              shut;
    } regs_t;

endpackage

// File: rtl/irqagg_monitor.sv
module irqagg_monitor
    import irqagg_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int DW   = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    output logic [DW-1:0]   mon_d_o,
    output logic [DW-1:0]   mon_q_o
);

    logic [DW-1:0] mon_d, mon_q;

    always_comb begin
        mon_d = '0;
        for (int i = 0; i < NSRC; i++) begin
            mon_d[src_bit(i)] = req_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign mon_d_o = mon_d;
    assign mon_q_o = mon_q;

endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio
    import irqagg_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int DW   = DATA_W,
    parameter int LW   = LEVEL_W
) (
    input  logic [DW-1:0] word_i,
    output logic [LW-1:0] code_o
);

    localparam logic [LW-1:0] IDLE_LVL = '1;

    logic [NSRC-1:0] hit;
    logic [LW-1:0]   sel;
    logic            unused_word;

    for (genvar g = 0; g < NSRC; g++) begin : g_hit
        assign hit[g] = word_i[src_bit(g)];
    end

    assign unused_word = ^word_i;

    always_comb begin
        sel = IDLE_LVL;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) sel = LW'(i);
        end
        code_o = sel ^ IDLE_LVL;
    end

endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] mask_d_o,
    output logic [DW-1:0] mask_q_o,
    output logic [DW-1:0] port_o,
    output logic          shut_o
);

    regs_t r_d, r_q;
    logic  wr_en;

    assign wr_en = sel_i & wr_i;

    always_comb begin
        r_d      = r_q;
        r_d.shut = 1'b0;
        if (wr_en) begin
            case (addr_i)
                OFS_MASK:  r_d.mask = wdata_i;
                OFS_PORT:  r_d.port = wdata_i;
                OFS_POWER: r_d.shut = wdata_i[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            case (addr_i)
                OFS_MASK: rdata_o = r_q.mask;
                OFS_PORT: rdata_o = r_q.port;
                OFS_VER:  rdata_o = VERSION_WORD;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign mask_d_o = r_d.mask;
    assign mask_q_o = r_q.mask;
    assign port_o   = r_q.port;
    assign shut_o   = r_q.shut;

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_i == OFS_MASK) |=> $stable(mask_q_o));

    // R6
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_i == OFS_PORT) |=> $stable(port_o));

    // R8
    shut_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shut_o |-> $past(wr_en && addr_i == OFS_POWER && wdata_i[0]));

endmodule

// File: rtl/irq_level_agg.sv
module irq_level_agg
    import irqagg_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int LW   = LEVEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic [AW-1:0]   bus_addr_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic [LW-1:0]   irq_level_o,
    output logic [DW-1:0]   port_o,
    output logic            shutdown_o
);

    typedef struct packed {
        logic [LW-1:0] code;
    } out_t;

    logic [DW-1:0] mon_d, mon_q, mask_d, mask_q;
    logic [LW-1:0] code_next;
    out_t          o_d, o_q;

    irqagg_monitor #(.NSRC(NSRC), .DW(DW)) mon_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (src_req_i),
        .mon_d_o (mon_d),
        .mon_q_o (mon_q)
    );

    irqagg_regs #(.DW(DW), .AW(AW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .rdata_o  (bus_rdata_o),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q),
        .port_o   (port_o),
        .shut_o   (shutdown_o)
    );

    irqagg_prio #(.NSRC(NSRC), .DW(DW), .LW(LW)) prio_i (
        .word_i (mon_d & mask_d),
        .code_o (code_next)
    );

    always_comb begin
        o_d      = o_q;
        o_d.code = code_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_level_o = o_q.code;

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mon_q & mask_q) == '0) |-> (irq_level_o == '0));

    // R2
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level_o != LW'(1)) && (irq_level_o != LW'(2)));

endmodule

// File: tb/irq_level_agg_tb_top.sv
`timescale 1ns/1ps
module irq_level_agg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] req = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  lvl;
    logic [15:0] port;
    logic        shut;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int mbit[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

    logic [15:0] m_mask = '0, m_port = '0;
    logic [3:0]  m_lvl = '0;
    logic        m_shut = 1'b0;

    always #4 clk = ~clk;

    irq_level_agg dut_i (
        .clk(clk), .rst_n(rst_n), .src_req_i(req),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_level_o(lvl), .port_o(port), .shutdown_o(shut)
    );

    function automatic int ref_level(logic [12:0] r, logic [15:0] m);
        for (int k = 0; k < 13; k++)
            if (r[k] && m[mbit[k]]) return k;
        return 15;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // Behavioural reference, updated on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '0; m_port = '0; m_lvl = '0; m_shut = 1'b0;
        end else begin
            if (sel && wr && addr == 6'h00) m_mask = wdata;
            if (sel && wr && addr == 6'h36) m_port = wdata;
            m_shut = sel && wr && addr == 6'h30 && wdata[0];
            m_lvl = 4'(ref_level(req, m_mask) ^ 15);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(lvl == m_lvl, "R4 level vs model", lvl, m_lvl);
            chk(shut == m_shut, "R8 shutdown vs model", shut, m_shut);
            chk(port == m_port, "R6 port vs model", port, m_port);
        end
    end

    task automatic idle_bus();
        sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        chk(rdata == exp, tag, rdata, exp);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic set_req(input logic [12:0] v);
        @(negedge clk);
        req = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(lvl == 4'd0, "R10 level after reset", lvl, 0);
        chk(shut == 1'b0, "R10 shutdown after reset", shut, 0);
        chk(port == 16'h0, "R10 port after reset", port, 0);
        rst_n = 1'b1;
        bus_read(6'h00, 16'h0000, "R10 mask after reset");
        bus_read(6'h36, 16'h0000, "R10 port reg after reset");

        // R2 mask clear: no source gets through
        set_req(13'h1FFF);
        chk(lvl == 4'd0, "R2 all masked gives idle", lvl, 0);

        // R5 mask readback and inert bits 1..3
        bus_write(6'h00, 16'h000E);
        bus_read(6'h00, 16'h000E, "R5 mask readback");
        chk(lvl == 4'd0, "R5 bits 1-3 do not enable", lvl, 0);

        // R1/R3 each source alone with full mask
        bus_write(6'h00, 16'hFFFF);
        for (int k = 0; k < 13; k++) begin
            set_req(13'(1) << k);
            chk(lvl == 4'(k ^ 15), "R1 single source level", lvl, k ^ 15);
        end
        set_req('0);
        chk(lvl == 4'd0, "R3 idle encodes zero", lvl, 0);

        // R2 priority between several sources
        set_req(13'h1001);
        chk(lvl == 4'hF, "R2 level 0 beats 12", lvl, 15);
        set_req(13'h1E00);
        chk(lvl == 4'h6, "R2 level 9 lowest of 9..12", lvl, 6);
        // disable level 0 (bit 11): level 12 wins of {0,12}
        set_req(13'h1001);
        bus_write(6'h00, 16'hF7FF);
        chk(lvl == 4'h3, "R2 masked winner falls to 12", lvl, 3);

        // R4 timing: no change before the edge, change after
        bus_write(6'h00, 16'hFFFF);
        @(negedge clk);
        req = 13'h0004;
        #1;
        chk(lvl == 4'hF, "R4 output holds before edge", lvl, 15);
        @(negedge clk);
        chk(lvl == 4'hD, "R4 output after one edge", lvl, 13);

        // R6 output port
        bus_write(6'h36, 16'hA5C3);
        chk(port == 16'hA5C3, "R6 port pin", port, 16'hA5C3);
        bus_read(6'h36, 16'hA5C3, "R6 port readback");

        // R7 version
        bus_write(6'h32, 16'hFFFF);
        bus_read(6'h32, 16'h0010, "R7 version after write");
        bus_read(6'h00, 16'hFFFF, "R7 mask untouched by version write");

        // R8 power-off
        bus_read(6'h30, 16'h0000, "R8 power-off reads zero");
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 6'h30; wdata = 16'h0001;
        @(negedge clk);
        idle_bus();
        chk(shut == 1'b1, "R8 pulse after write", shut, 1);
        @(negedge clk);
        chk(shut == 1'b0, "R8 pulse one cycle", shut, 0);
        bus_write(6'h30, 16'hFFFE);
        chk(shut == 1'b0, "R8 bit0 clear no pulse", shut, 0);

        // R9 other offsets
        bus_write(6'h02, 16'h0000);
        bus_write(6'h34, 16'h1234);
        bus_read(6'h00, 16'hFFFF, "R9 mask unchanged");
        bus_read(6'h36, 16'hA5C3, "R9 port unchanged");
        bus_read(6'h02, 16'h0000, "R9 other offset reads zero");
        bus_read(6'h3E, 16'h0000, "R9 top offset reads zero");

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            req = 13'($urandom);
            if (($urandom % 4) == 0) begin
                sel = 1'b1; wr = 1'b1;
                case ($urandom % 4)
                    0: addr = 6'h00;
                    1: addr = 6'h36;
                    2: addr = 6'h30;
                    default: addr = 6'($urandom);
                endcase
                wdata = 16'($urandom);
            end else begin
                idle_bus();
            end
        end
        @(negedge clk);
        idle_bus();

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(lvl == 4'd0, "R10 level in reset", lvl, 0);
        rst_n = 1'b1;
        bus_read(6'h00, 16'h0000, "R10 mask after second reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule